// File: doc/BRIEF.md
# Flash Write-Protection Command Front End

This block sits between the parallel bus of a flash memory and the engine that runs the program and erase algorithms. It decides which bus writes count. A write is kept only when the chip-select and write strobes were both low for a programmable number of clock samples, output-enable stayed high, the programming-supply lockout flag was clear and the power-down pin was high for the whole strobe-low window. An accepted write is latched when the first of the two strobes rises.

Accepted writes go to a small command sequencer. Array contents can change only after a two-write sequence. The first write is a setup code and the second is either the program data or the erase confirm code. A completed sequence is offered to the back end as one operation on a valid/ready channel. The operation stays pending, with its payload frozen, until the back end takes it. No new program or erase operation is accepted until the back end pulses done. The power-down pin aborts any operation, clears the error flags and returns the read path to array data.

The programming-supply comparator, the cell array and the algorithm timing are outside this block. They appear only as a lockout flag, an array read-data input and a done/fail handshake.

Top module: `flash_wp_frontend`

## Requirements
- R1: A strobe window during which `vpp_low` is high at any sample, or at the rising sample, is discarded and not queued. While `vpp_low` is high, `op_valid` is low. Once `vpp_low` clears, no write is accepted until a new strobe window occurs.
- R2: A write is taken only if `ce_n` and `we_n` are both low and `oe_n` is high. Sampling `oe_n` low at any point in the window, or at the rising sample, discards the write.
- R3: Each of `ce_n` and `we_n` must be sampled low on at least max(`min_low`,1) consecutive clock edges before the rise, or the pulse is ignored. With `min_low`=3, a 2-sample pulse is dropped and a 3-sample pulse is taken. With `min_low`=0, a 1-sample pulse is taken.
- R4: After `rst_n` the read path is in array mode, so `dout` equals `array_rdata`. Command 0xFF selects array mode from the idle state.
- R5: Command 0x70 selects status mode, so `dout` equals `sr` zero-extended. `sr` bit 7 is ready, bit 5 is the sticky erase error, bit 4 is the sticky program error, and all other bits are 0. The value after reset is 0x80.
- R6: Command 0x40 followed by any write raises `op_valid` with `op_erase`=0. `op_addr` and `op_data` hold the address and data latched from the second write. The setup write also switches the read path to status mode.
- R7: Command 0x20 followed by 0xD0 raises `op_valid` with `op_erase`=1 and the address of the confirm write.
- R8: If the write after 0x20 is not 0xD0, no operation is issued, `sr` bit 5 is set and the sequencer returns to idle.
- R9: `op_valid` holds with stable `op_erase`, `op_addr` and `op_data` until `op_ready` is sampled high. `sr` bit 7 is low from issue until `be_done`. A `be_done` with `be_fail` high sets bit 4 (program) or bit 5 (erase).
- R10: While `sr` bit 7 is low, every command except 0x70 is ignored.
- R11: When `rp_n` is sampled low, the sequencer returns to idle in array mode with `sr` cleared to 0x80 and `op_valid` low. During a pending or running operation, `op_abort` is high while `rp_n` is low.
- R12: `dq_oe` is high exactly when `rp_n`, `we_n` and `oe_n`... are such that `rp_n` is high, `we_n` is high, and both `ce_n` and `oe_n` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| rp_n | input | 1 | Reset / deep power-down pin, active low |
| vpp_low | input | 1 | Programming supply below lockout threshold |
| min_low | input | CNT_W | Minimum consecutive low samples per strobe |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| din | input | DW | Bus write data |
| array_rdata | input | DW | Data read from the cell array |
| dout | output | DW | Read data for the bus |
| dq_oe | output | 1 | Data bus drive enable |
| sr | output | 8 | Status register |
| op_valid | output | 1 | Operation offered to the back end |
| op_ready | input | 1 | Back end takes the operation |
| op_erase | output | 1 | 1 = erase, 0 = program |
| op_addr | output | AW | Operation address |
| op_data | output | DW | Program data |
| be_done | input | 1 | Back end finished (one-cycle pulse) |
| be_fail | input | 1 | Qualifies `be_done` as failed |
| op_abort | output | 1 | Abort request to the back end |

## Verification
The bench builds the block with AW=8, DW=16 and CNT_W=4. A 16-bit data path shows that status is zero-extended while array data passes through whole. A 4-bit counter lets `min_low` be set to 3, so the 2-sample and 3-sample pulse lengths fall on either side of the filter threshold. The bench also sets `min_low` to 0 to reach the lower clamp, where a single-sample pulse counts. Holding `op_ready` low for several cycles exposes the pending-operation hold and the command gating while busy.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_CONF  = 8'hD0;
  localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;

  localparam int SR_READY_BIT = 7;
  localparam int SR_EERR_BIT  = 5;
  localparam int SR_PERR_BIT  = 4;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PSETUP,
    SEQ_ESETUP,
    SEQ_ISSUE,
    SEQ_WAIT
  } seq_state_t;
endpackage

// File: rtl/fcf_deglitch.sv
module fcf_deglitch #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_n,
  input  logic [CNT_W-1:0] min_low,
  output logic             filt_low
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, thr;
  logic             filt_q;

  // a zero threshold still needs one low sample
  assign thr = (min_low == '0) ? CNT_ONE : min_low;

  always_comb begin
    if (raw_n)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= !raw_n && (cnt_d >= thr);
    end
  end

  assign filt_low = filt_q;
endmodule

// File: rtl/fcf_strobe_qual.sv
module fcf_strobe_qual #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             vpp_low,
  input  logic             rp_n,
  input  logic [CNT_W-1:0] min_low,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic             wr_valid,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data
);
  localparam int NSTROBE = 2;

  logic [NSTROBE-1:0] strobe_n;
  logic [NSTROBE-1:0] filt;
  logic               both_low_q;
  logic               inh_q;
  logic               any_high;
  logic               accept;
  logic               wv_q;
  logic [AW-1:0]      wa_q;
  logic [DW-1:0]      wd_q;

  assign strobe_n = {we_n, ce_n};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_filt
    fcf_deglitch #(.CNT_W(CNT_W)) u_dg (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_n    (strobe_n[g]),
      .min_low  (min_low),
      .filt_low (filt[g])
    );
  end

  assign any_high = ce_n | we_n;

  // rising edge of the combined strobe, all guards clean over the window
  assign accept = both_low_q && any_high && (&filt) && !inh_q &&
                  oe_n && !vpp_low && rp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_low_q <= 1'b0;
      inh_q      <= 1'b0;
      wv_q       <= 1'b0;
      wa_q       <= '0;
      wd_q       <= '0;
    end else begin
      both_low_q <= !any_high;
      if (any_high) inh_q <= 1'b0;
      else          inh_q <= inh_q | !oe_n | vpp_low | !rp_n;
      wv_q <= accept;
      if (accept) begin
        wa_q <= addr;
        wd_q <= din;
      end
    end
  end

  assign wr_valid = wv_q;
  assign wr_addr  = wa_q;
  assign wr_data  = wd_q;
endmodule

// File: rtl/fcf_cmd_seq.sv
module fcf_cmd_seq
  import fcf_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rp_n,
  input  logic          vpp_low,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          op_valid,
  input  logic          op_ready,
  output logic          op_erase,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  input  logic          be_done,
  input  logic          be_fail,
  output logic          op_abort,
  output logic          show_status,
  output logic [7:0]    sr
);
  seq_state_t    st_q;
  logic          stat_mode_q;
  logic          perr_q, eerr_q;
  logic          kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [7:0]    cmd;
  logic          busy;

  assign cmd  = wr_data[7:0];
  assign busy = (st_q == SEQ_ISSUE) || (st_q == SEQ_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_IDLE;
      stat_mode_q <= 1'b0;
      perr_q      <= 1'b0;
      eerr_q      <= 1'b0;
      kind_q      <= 1'b0;
      addr_q      <= '0;
      data_q      <= '0;
    end else if (!rp_n) begin
      st_q        <= SEQ_IDLE;
      stat_mode_q <= 1'b0;
      perr_q      <= 1'b0;
      eerr_q      <= 1'b0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (wr_valid) begin
          unique case (cmd)
            CMD_RD_ARRAY:    stat_mode_q <= 1'b0;
            CMD_RD_STATUS:   stat_mode_q <= 1'b1;
            CMD_PROG_SETUP: begin
              st_q        <= SEQ_PSETUP;
              stat_mode_q <= 1'b1;
            end
            CMD_ERASE_SETUP: begin
              st_q        <= SEQ_ESETUP;
              stat_mode_q <= 1'b1;
            end
            default: ;
          endcase
        end
        SEQ_PSETUP: if (wr_valid) begin
          st_q   <= SEQ_ISSUE;
          kind_q <= 1'b0;
          addr_q <= wr_addr;
          data_q <= wr_data;
        end
        SEQ_ESETUP: if (wr_valid) begin
          if (cmd == CMD_ERASE_CONF) begin
            st_q   <= SEQ_ISSUE;
            kind_q <= 1'b1;
            addr_q <= wr_addr;
            data_q <= '0;
          end else begin
            st_q   <= SEQ_IDLE;
            eerr_q <= 1'b1;
          end
        end
        SEQ_ISSUE: begin
          if (wr_valid && cmd == CMD_RD_STATUS) stat_mode_q <= 1'b1;
          if (op_valid && op_ready) st_q <= SEQ_WAIT;
        end
        SEQ_WAIT: begin
          if (wr_valid && cmd == CMD_RD_STATUS) stat_mode_q <= 1'b1;
          if (be_done) begin
            st_q <= SEQ_IDLE;
            if (be_fail) begin
              if (kind_q) eerr_q <= 1'b1;
              else        perr_q <= 1'b1;
            end
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign op_valid    = (st_q == SEQ_ISSUE) && !vpp_low;
  assign op_erase    = kind_q;
  assign op_addr     = addr_q;
  assign op_data     = data_q;
  assign op_abort    = busy && !rp_n;
  assign show_status = stat_mode_q;

  always_comb begin
    sr               = '0;
    sr[SR_READY_BIT] = !busy;
    sr[SR_EERR_BIT]  = eerr_q;
    sr[SR_PERR_BIT]  = perr_q;
  end
endmodule

// File: rtl/flash_wp_frontend.sv
module flash_wp_frontend #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rp_n,
  input  logic             vpp_low,
  input  logic [CNT_W-1:0] min_low,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    array_rdata,
  output logic [DW-1:0]    dout,
  output logic             dq_oe,
  output logic [7:0]       sr,
  output logic             op_valid,
  input  logic             op_ready,
  output logic             op_erase,
  output logic [AW-1:0]    op_addr,
  output logic [DW-1:0]    op_data,
  input  logic             be_done,
  input  logic             be_fail,
  output logic             op_abort
);
  localparam int SR_W = 8;

  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          show_status;

  fcf_strobe_qual #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .vpp_low  (vpp_low),
    .rp_n     (rp_n),
    .min_low  (min_low),
    .addr     (addr),
    .din      (din),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  fcf_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .rp_n        (rp_n),
    .vpp_low     (vpp_low),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .op_valid    (op_valid),
    .op_ready    (op_ready),
    .op_erase    (op_erase),
    .op_addr     (op_addr),
    .op_data     (op_data),
    .be_done     (be_done),
    .be_fail     (be_fail),
    .op_abort    (op_abort),
    .show_status (show_status),
    .sr          (sr)
  );

  if (DW > SR_W) begin : g_wide
    assign dout = show_status ? {{(DW-SR_W){1'b0}}, sr} : array_rdata;
  end else begin : g_narrow
    assign dout = show_status ? sr[DW-1:0] : array_rdata;
  end

  assign dq_oe = rp_n && !ce_n && !oe_n && we_n;
endmodule

// File: rtl/flash_wp_frontend_chk.sv
module flash_wp_frontend_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rp_n,
  input logic          vpp_low,
  input logic          oe_n,
  input logic          wr_valid,
  input logic          op_valid,
  input logic          op_ready,
  input logic [AW-1:0] op_addr,
  input logic [DW-1:0] op_data,
  input logic          op_erase,
  input logic          be_done,
  input logic [7:0]    sr
);
  // R1: lockout at a sample leaves no accepted write after it
  a_r1_lockout_drops: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_low |=> !wr_valid);

  // R2: output-enable low inhibits acceptance
  a_r2_oe_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |=> !wr_valid);

  // R9: pending operation is held with a frozen payload
  a_r9_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready && rp_n) |=>
      ((op_valid || vpp_low) && $stable(op_addr) && $stable(op_data) && $stable(op_erase)));

  // R9: handshake drops the ready bit
  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && rp_n) |=> !sr[7]);

  // R10: busy persists until the back end reports done
  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr[7] && rp_n && !be_done) |=> !sr[7]);

  // R11: power-down clears status and withdraws the operation
  a_r11_rp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (sr == 8'h80 && !op_valid));
endmodule

bind flash_wp_frontend flash_wp_frontend_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rp_n     (rp_n),
  .vpp_low  (vpp_low),
  .oe_n     (oe_n),
  .wr_valid (wr_valid),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .op_addr  (op_addr),
  .op_data  (op_data),
  .op_erase (op_erase),
  .be_done  (be_done),
  .sr       (sr)
);

// File: tb/flash_wp_frontend_test.sv
`timescale 1ns/1ps
module flash_wp_frontend_test;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CNT_W = 4;
  localparam logic [DW-1:0] ARR = 16'h5A5A;

  logic clk = 1'b0;
  logic rst_n, rp_n, vpp_low, ce_n, we_n, oe_n;
  logic [CNT_W-1:0] min_low;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, array_rdata, dout, op_data;
  logic dq_oe, op_valid, op_ready, op_erase, be_done, be_fail, op_abort;
  logic [7:0] sr;
  logic [AW-1:0] op_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  flash_wp_frontend #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .vpp_low(vpp_low), .min_low(min_low),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .array_rdata(array_rdata), .dout(dout), .dq_oe(dq_oe), .sr(sr),
    .op_valid(op_valid), .op_ready(op_ready), .op_erase(op_erase),
    .op_addr(op_addr), .op_data(op_data), .be_done(be_done), .be_fail(be_fail),
    .op_abort(op_abort)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (len) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R4 reset dout array", dout, ARR);
    check("R5 reset sr", sr, 8'h80);
    check("R11 reset op_valid", op_valid, 0);
  endtask

  task automatic t_glitch();
    min_low = 3;
    bus_write(8'h00, 16'h0070, 2);
    check("R3 2-sample pulse dropped", dout, ARR);
    bus_write(8'h00, 16'h0070, 3);
    check("R3 3-sample pulse taken", dout, 16'h0080);
    bus_write(8'h00, 16'h00FF, 3);
    check("R4 0xFF back to array", dout, ARR);
    min_low = 0;
    bus_write(8'h00, 16'h0070, 1);
    check("R3 min_low 0 single sample", dout, 16'h0080);
    bus_write(8'h00, 16'h00FF, 1);
    min_low = 3;
  endtask

  task automatic t_lockout();
    vpp_low = 1'b1;
    bus_write(8'h00, 16'h0070, 4);
    check("R1 write in lockout dropped", dout, ARR);
    vpp_low = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 nothing queued", dout, ARR);
    bus_write(8'h00, 16'h0070, 4);
    check("R1 accepted after lockout", dout, 16'h0080);
    bus_write(8'h00, 16'h00FF, 4);
  endtask

  task automatic t_oe_inhibit();
    oe_n = 1'b0;
    bus_write(8'h00, 16'h0070, 4);
    oe_n = 1'b1;
    @(negedge clk);
    check("R2 oe low inhibits", dout, ARR);
  endtask

  task automatic t_program();
    bus_write(8'h00, 16'h0040, 4);
    check("R6 setup selects status", dout, 16'h0080);
    bus_write(8'h12, 16'hABCD, 4);
    check("R6 op_valid", op_valid, 1);
    check("R6 op_erase", op_erase, 0);
    check("R6 op_addr", op_addr, 8'h12);
    check("R6 op_data", op_data, 16'hABCD);
    check("R9 ready low while pending", dout, 16'h0000);
    bus_write(8'h00, 16'h00FF, 4);
    check("R10 0xFF ignored when busy", dout, 16'h0000);
    check("R9 still pending", op_valid, 1);
    op_ready = 1'b1;
    @(negedge clk);
    op_ready = 1'b0;
    check("R9 taken", op_valid, 0);
    check("R9 busy after take", sr, 8'h00);
    be_done = 1'b1; be_fail = 1'b1;
    @(negedge clk);
    be_done = 1'b0; be_fail = 1'b0;
    @(negedge clk);
    check("R9 program fail sets bit 4", dout, 16'h0090);
  endtask

  task automatic t_erase_bad();
    bus_write(8'h00, 16'h0020, 4);
    bus_write(8'h00, 16'h0055, 4);
    check("R8 no op on bad confirm", op_valid, 0);
    check("R8 erase error set", dout, 16'h00B0);
  endtask

  task automatic t_rp_clear();
    @(negedge clk); rp_n = 1'b0;
    @(negedge clk); rp_n = 1'b1;
    @(negedge clk);
    check("R11 status cleared", sr, 8'h80);
    check("R11 array mode", dout, ARR);
  endtask

  task automatic t_erase_abort();
    bus_write(8'h00, 16'h0020, 4);
    bus_write(8'h34, 16'h00D0, 4);
    check("R7 op_valid", op_valid, 1);
    check("R7 op_erase", op_erase, 1);
    check("R7 op_addr", op_addr, 8'h34);
    op_ready = 1'b1;
    @(negedge clk);
    op_ready = 1'b0;
    rp_n = 1'b0;
    #1;
    check("R11 abort during op", op_abort, 1);
    @(negedge clk);
    rp_n = 1'b1;
    @(negedge clk);
    check("R11 abort released", op_abort, 0);
    check("R11 ready after abort", sr, 8'h80);
    check("R11 array after abort", dout, ARR);
  endtask

  task automatic t_dq_oe();
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 check("R12 read drive on", dq_oe, 1);
    rp_n = 1'b0;
    #1 check("R12 power-down tristates", dq_oe, 0);
    rp_n = 1'b1; we_n = 1'b0;
    #1 check("R12 we low no drive", dq_oe, 0);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rp_n = 1'b1; vpp_low = 1'b0; min_low = 3;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
    array_rdata = ARR; op_ready = 1'b0; be_done = 1'b0; be_fail = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_glitch();
    t_lockout();
    t_oe_inhibit();
    t_program();
    t_erase_bad();
    t_rp_clear();
    t_erase_abort();
    t_dq_oe();
    finish_run();
  end
endmodule